// File: doc/BRIEF.md
# Integrating Power Meter with Result Handshake

The block measures the energy of a complex sample stream. Each valid sample contributes I squared plus Q squared, computed from signed components. These terms are added into a saturating accumulator over a window set by a free-running 16-bit integration timer. The window closes when the timer reaches a programmed terminal count or when an external sync strobe restarts it. At that moment the accumulated sum is latched into a result register, a ready flag rises and the accumulator starts over.

Software reads the result as two halves. It then pulses an acknowledge that drops the ready flag. Two sticky status flags report misuse of this handshake. One flags a result that was overwritten before it was acknowledged. The other flags an acknowledge given when no result was pending. Each sticky flag is cleared by its own write-one-to-clear strobe. The first result after a sync covers a partial window, and software is expected to discard it.

Top module: `pm_power_meter`

## Requirements
- R1: After reset the status word, the low result half and the high result half all read zero.
- R2: With no sync, a window closes every term_cnt_i+1 clocks. The closing cycle latches the sum of the earlier valid terms of that window. The sample taken in the closing cycle counts toward the next window.
- R3: A sample contributes i*i + q*q (both two's-complement) only when smp_valid_i is high. Samples without valid add nothing.
- R4: The accumulator saturates at all ones (0xFFFFFFFF for a 32-bit accumulator) instead of wrapping.
- R5: A sync strobe restarts the timer and closes the window in the same cycle, so ready (status bit 15) is high on the next clock.
- R6: A window close sets ready. An acknowledge without a concurrent close clears it on the next clock.
- R7: A window close while ready is high and no acknowledge is present sets the missed flag (status bit 14). The flag then stays set.
- R8: An acknowledge while ready is low sets the too_soon flag (status bit 13). An acknowledge while ready is high leaves too_soon clear.
- R9: A pulse on clr_missed_i or clr_toosoon_i clears the matching flag. If a set condition occurs in the same cycle, the flag stays set.
- R10: The latched result changes only at a window close. pwr_lo_o carries bits 15:0 and pwr_hi_o carries bits 31:16. Status bits 12:0 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Sample qualifier |
| smp_i_i | input | DW | In-phase component, signed |
| smp_q_i | input | DW | Quadrature component, signed |
| sync_i | input | 1 | Restarts the integration timer and closes the window |
| term_cnt_i | input | TW | Terminal count of the integration timer |
| ack_i | input | 1 | Read acknowledge pulse, clears ready |
| clr_missed_i | input | 1 | Write-one-to-clear strobe for missed |
| clr_toosoon_i | input | 1 | Write-one-to-clear strobe for too_soon |
| pwr_lo_o | output | AW/2 | Latched result, low half |
| pwr_hi_o | output | AW/2 | Latched result, high half |
| status_o | output | 16 | Bit 15 ready, bit 14 missed, bit 13 too_soon, rest zero |

## Verification
A timer count that drifts from its intended value shows up as ready rising on the wrong clock. The windowed test counts clocks from a sync and exposes this within one window. An accumulator that is not fully cleared, or that leaks a done-cycle sample into the wrong window, corrupts the very next latched result. Back-to-back periodic windows make that visible in the second one. A wrong flag register shows on status_o one clock after the triggering acknowledge, close or clear, and every such event is followed by a read of the status word.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int unsigned STAT_W      = 16;
    localparam int unsigned ST_READY    = 15;
    localparam int unsigned ST_MISSED   = 14;
    localparam int unsigned ST_TOO_SOON = 13;
endpackage

// File: rtl/pm_power_term.sv
module pm_power_term #(
    parameter int unsigned DW = 16,
    localparam int unsigned PW = 2 * DW + 1
) (
    input  logic                 valid_i,
    input  logic signed [DW-1:0] i_i,
    input  logic signed [DW-1:0] q_i,
    output logic [PW-1:0]        term_o
);
    logic signed [2*DW-1:0] ii_sq;
    logic signed [2*DW-1:0] qq_sq;

    always_comb begin
        ii_sq  = (2*DW)'(i_i) * (2*DW)'(i_i);
        qq_sq  = (2*DW)'(q_i) * (2*DW)'(q_i);
        term_o = valid_i ? (PW'(ii_sq) + PW'(qq_sq)) : '0;
    end
endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_i,
    input  logic [TW-1:0] term_i,
    output logic          done_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        done_o = sync_i || (cnt_q == term_i);
        cnt_d  = done_o ? '0 : cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pm_accum.sv
module pm_accum #(
    parameter int unsigned AW = 32,
    parameter int unsigned PW = 33
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic [PW-1:0] term_i,
    output logic [AW-1:0] acc_o
);
    localparam int unsigned SW = ((AW > PW) ? AW : PW) + 1;
    localparam logic [SW-1:0] LIMIT = SW'({AW{1'b1}});

    logic [AW-1:0] acc_d, acc_q;
    logic [SW-1:0] base;
    logic [SW-1:0] sum;

    always_comb begin
        base  = restart_i ? '0 : SW'(acc_q);
        sum   = base + SW'(term_i);
        acc_d = (sum > LIMIT) ? {AW{1'b1}} : sum[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/pm_power_meter.sv
module pm_power_meter
    import pm_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned TW = 16,
    parameter int unsigned AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid_i,
    input  logic signed [DW-1:0] smp_i_i,
    input  logic signed [DW-1:0] smp_q_i,
    input  logic                 sync_i,
    input  logic [TW-1:0]        term_cnt_i,
    input  logic                 ack_i,
    input  logic                 clr_missed_i,
    input  logic                 clr_toosoon_i,
    output logic [AW/2-1:0]      pwr_lo_o,
    output logic [AW/2-1:0]      pwr_hi_o,
    output logic [STAT_W-1:0]    status_o
);
    localparam int unsigned PW = 2 * DW + 1;
    localparam int unsigned HW = AW / 2;

    typedef struct packed {
        logic [AW-1:0] result;
        logic          ready;
        logic          missed;
        logic          too_soon;
    } meter_st_t;

    meter_st_t     st_d, st_q;
    logic          tmr_done;
    logic [PW-1:0] term;
    logic [AW-1:0] acc;

    pm_power_term #(.DW(DW)) u_term (
        .valid_i (smp_valid_i),
        .i_i     (smp_i_i),
        .q_i     (smp_q_i),
        .term_o  (term)
    );

    pm_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_i),
        .term_i (term_cnt_i),
        .done_o (tmr_done)
    );

    pm_accum #(.AW(AW), .PW(PW)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (tmr_done),
        .term_i    (term),
        .acc_o     (acc)
    );

    always_comb begin
        st_d = st_q;
        if (tmr_done) begin
            st_d.result = acc;
        end
        if (tmr_done)   st_d.ready = 1'b1;
        else if (ack_i) st_d.ready = 1'b0;
        st_d.missed   = (tmr_done && st_q.ready && !ack_i)
                     || (st_q.missed && !clr_missed_i);
        st_d.too_soon = (ack_i && !st_q.ready)
                     || (st_q.too_soon && !clr_toosoon_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        pwr_lo_o              = st_q.result[HW-1:0];
        pwr_hi_o              = st_q.result[AW-1:HW];
        status_o              = '0;
        status_o[ST_READY]    = st_q.ready;
        status_o[ST_MISSED]   = st_q.missed;
        status_o[ST_TOO_SOON] = st_q.too_soon;
    end
endmodule

// File: rtl/pm_checks.sv
module pm_checks
    import pm_pkg::*;
#(
    parameter int unsigned RW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_i,
    input logic              ack_i,
    input logic              clr_missed_i,
    input logic              clr_toosoon_i,
    input logic              done_i,
    input logic [STAT_W-1:0] status_i,
    input logic [RW-1:0]     result_i
);
    AST_SYNC_READY: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> status_i[ST_READY]); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !done_i) |=> !status_i[ST_READY]); // R6
    AST_MISSED_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && status_i[ST_READY] && !ack_i) |=> status_i[ST_MISSED]); // R7
    AST_TOO_SOON_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !status_i[ST_READY]) |=> status_i[ST_TOO_SOON]); // R8
    AST_MISSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_i[ST_MISSED] && !clr_missed_i) |=> status_i[ST_MISSED]); // R9
    AST_TOO_SOON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_i[ST_TOO_SOON] && !clr_toosoon_i) |=> status_i[ST_TOO_SOON]); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(result_i)); // R10
endmodule

bind pm_power_meter pm_checks #(.RW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sync_i        (sync_i),
    .ack_i         (ack_i),
    .clr_missed_i  (clr_missed_i),
    .clr_toosoon_i (clr_toosoon_i),
    .done_i        (tmr_done),
    .status_i      (status_o),
    .result_i      ({pwr_hi_o, pwr_lo_o})
);

// File: tb/test_pm_power_meter.sv
module test_pm_power_meter;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_valid_i = 1'b0;
    logic signed [15:0] smp_i_i = '0;
    logic signed [15:0] smp_q_i = '0;
    logic               sync_i = 1'b0;
    logic [15:0]        term_cnt_i = 16'd1000;
    logic               ack_i = 1'b0;
    logic               clr_missed_i = 1'b0;
    logic               clr_toosoon_i = 1'b0;
    logic [15:0]        pwr_lo_o;
    logic [15:0]        pwr_hi_o;
    logic [15:0]        status_o;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    pm_power_meter i_pm_power_meter (
        .clk           (clk),
        .rst_n         (rst_n),
        .smp_valid_i   (smp_valid_i),
        .smp_i_i       (smp_i_i),
        .smp_q_i       (smp_q_i),
        .sync_i        (sync_i),
        .term_cnt_i    (term_cnt_i),
        .ack_i         (ack_i),
        .clr_missed_i  (clr_missed_i),
        .clr_toosoon_i (clr_toosoon_i),
        .pwr_lo_o      (pwr_lo_o),
        .pwr_hi_o      (pwr_hi_o),
        .status_o      (status_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_sync();
        sync_i = 1'b1; cyc(); sync_i = 1'b0;
    endtask

    task automatic do_ack();
        ack_i = 1'b1; cyc(); ack_i = 1'b0;
    endtask

    task automatic sample(int i, int q);
        smp_valid_i = 1'b1; smp_i_i = 16'(i); smp_q_i = 16'(q);
        cyc();
        smp_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 status", {16'h0, status_o}, 32'h0);
        check("R1 result", {pwr_hi_o, pwr_lo_o}, 32'h0);
    endtask

    task automatic t_basic();
        do_sync();
        check("R5 ready after sync", {16'h0, status_o}, 32'h8000);
        check("R10 first result", {pwr_hi_o, pwr_lo_o}, 32'h0);
        do_ack();
        check("R6 ack clears ready, R8 no too_soon", {16'h0, status_o}, 32'h0);
        sample(3, 4);
        sample(-5, 12);
        sample(-7, -1);
        smp_i_i = 16'sd100; smp_q_i = 16'sd100;
        cyc();
        check("R10 result held between closes", {pwr_hi_o, pwr_lo_o}, 32'h0);
        do_sync();
        check("R3 sum of squares", {pwr_hi_o, pwr_lo_o}, 32'd244);
        do_ack();
    endtask

    task automatic t_sat();
        sample(32767, 32767);
        do_sync();
        check("R10 low half", {16'h0, pwr_lo_o}, 32'h0002);
        check("R10 high half", {16'h0, pwr_hi_o}, 32'h7FFE);
        do_ack();
        sample(-32768, -32768);
        sample(-32768, -32768);
        sample(1, 0);
        do_sync();
        check("R4 saturated", {pwr_hi_o, pwr_lo_o}, 32'hFFFF_FFFF);
        do_ack();
    endtask

    task automatic t_window();
        bit early;
        term_cnt_i = 16'd9;
        do_sync();
        smp_valid_i = 1'b1; smp_i_i = 16'sd1; smp_q_i = 16'sd0;
        ack_i = 1'b1; cyc(); ack_i = 1'b0;
        early = 1'b0;
        for (int k = 0; k < 8; k++) begin
            cyc();
            if (status_o[15]) early = 1'b1;
        end
        check("R2 no early close", {31'h0, early}, 32'h0);
        cyc();
        check("R2 close after term+1", {31'h0, status_o[15]}, 32'h1);
        check("R2 first window sum", {pwr_hi_o, pwr_lo_o}, 32'd9);
        ack_i = 1'b1; cyc(); ack_i = 1'b0;
        for (int k = 0; k < 8; k++) cyc();
        cyc();
        check("R2 second window sum", {pwr_hi_o, pwr_lo_o}, 32'd10);
        smp_valid_i = 1'b0;
        do_ack();
        term_cnt_i = 16'd1000;
        do_sync();
        do_ack();
        check("R2 clean status after window", {16'h0, status_o}, 32'h0);
    endtask

    task automatic t_missed();
        do_sync();
        do_sync();
        check("R7 missed set", {16'h0, status_o}, 32'hC000);
        cyc(); cyc(); cyc();
        check("R7 missed sticky", {16'h0, status_o}, 32'hC000);
        clr_missed_i = 1'b1; cyc(); clr_missed_i = 1'b0;
        check("R9 missed cleared", {16'h0, status_o}, 32'h8000);
        sync_i = 1'b1; clr_missed_i = 1'b1; cyc();
        sync_i = 1'b0; clr_missed_i = 1'b0;
        check("R9 set wins over clear", {16'h0, status_o}, 32'hC000);
        clr_missed_i = 1'b1; cyc(); clr_missed_i = 1'b0;
        do_ack();
        check("R9 missed clear then ack", {16'h0, status_o}, 32'h0);
    endtask

    task automatic t_toosoon();
        do_ack();
        check("R8 too_soon set", {16'h0, status_o}, 32'h2000);
        cyc(); cyc();
        check("R8 too_soon sticky", {16'h0, status_o}, 32'h2000);
        clr_toosoon_i = 1'b1; cyc(); clr_toosoon_i = 1'b0;
        check("R9 too_soon cleared", {16'h0, status_o}, 32'h0);
        ack_i = 1'b1; clr_toosoon_i = 1'b1; cyc();
        ack_i = 1'b0; clr_toosoon_i = 1'b0;
        check("R9 too_soon set wins", {16'h0, status_o}, 32'h2000);
        clr_toosoon_i = 1'b1; cyc(); clr_toosoon_i = 1'b0;
        do_sync();
        do_ack();
        check("R8 ack with ready high", {16'h0, status_o}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) cyc();
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_basic();
        t_sat();
        t_window();
        t_missed();
        t_toosoon();
        summary();
    end
endmodule